// File: doc/BRIEF.md
# Register-Window Packet Byte Port

This block is a small network-style peripheral that a processor drives through a word-addressed register window while packets enter and leave on two byte streams. An arriving packet is collected into a one-packet receive store. When its final byte lands, the length is published and a receive-pending interrupt is raised. The processor then pulls the bytes one at a time from a fixed data port, and each read lowers the published count.

To send, the processor programs a length and pushes that many bytes into a fixed transmit data port. The block then streams the stored packet out under valid/ready flow control and raises a transmit-done interrupt when the final byte is accepted.

One level interrupt output combines the two pending flags with a software self-test request. Receive is organised around the states RX_IDLE (waiting for a first byte), RX_FILL (collecting bytes) and RX_HOLD (packet published, input stalled). Its transitions are:
- first-beat from RX_IDLE to RX_FILL.
- short-packet from RX_IDLE straight to RX_HOLD, when the first byte is also the last.
- last-beat from RX_FILL to RX_HOLD.
- acknowledge from RX_HOLD to RX_IDLE.

Transmit uses the states TX_IDLE, TX_LOAD (processor filling the store) and TX_SEND (stream out). Its transitions are:
- arm from TX_IDLE to TX_LOAD, on a non-zero length write.
- filled from TX_LOAD to TX_SEND, on the byte that completes the length.
- drained from TX_SEND to TX_IDLE, on the handshake of the final byte.

Top module: `pktport_top`

## Requirements
- R1: Word reads return fixed values. Words 0 and 1 (byte offsets 0x00, 0x04) return the low and high halves of the 64-bit ASCII identification parameter DEV_ID. Word 6 (0x18) returns the parameter IRQ_LINE. Word 8 (0x20) and words 9 to 15 read 0. Writes to read-only words change nothing.
- R2: When the final byte of an incoming packet is accepted, word 3 (0x0C, receive count) reads the packet length and interrupt control bit 1 (receive pending) is set. The count reads 0 from the acceptance of a packet's first byte until its last.
- R3: Each read of word 7 (0x1C) returns the next received byte in arrival order, in bits 7:0 with the upper bits 0, and lowers the receive count by one. With the count at 0, a read returns 0 and the count stays 0.
- R4: While bit 1 is set, rx_ready is low and no bytes are taken. Writing interrupt control with bit 1 = 1 clears it and re-opens the input. Writing bit 1 while it is clear has no effect.
- R5: Bytes beyond MAX_LEN in one incoming packet are discarded. The count then reads MAX_LEN, and the stored bytes are the first MAX_LEN.
- R6: A write to word 4 (0x10, transmit count) arms transmit only in TX_IDLE and only when the value is non-zero. Values above MAX_LEN are cut to MAX_LEN. The word reads the armed length until the last byte is written, and 0 otherwise.
- R7: Writes to word 8 store bits 7:0 as successive packet bytes only in TX_LOAD; all others are ignored. The stored bytes leave on tx_data in order with tx_last on the final one. tx_valid and tx_data hold steady while tx_ready is low.
- R8: Interrupt control bit 0 (transmit done) sets on the final transmit handshake. Writing bit 0 = 1 clears it; when both happen in one cycle, the set wins.
- R9: Writing interrupt control with bit 31 = 1 raises the test interrupt and sets bit 31. The first read of word 5 (0x14) afterwards shows bit 31 = 1 and clears it. The test interrupt stays until a write of exactly 0 to word 5.
- R10: irq is the OR of bit 0, bit 1 and the test interrupt.
- R11: Word 2 (0x08) reads 1 while in RX_FILL or TX_SEND, else 0.
- R12: After reset, irq and tx_valid are 0, rx_ready is 1, and every count, flag and busy reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| rx_data | input | 8 | Incoming packet byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_last | input | 1 | Incoming byte is the packet's last |
| rx_ready | output | 1 | Block accepts an incoming byte |
| tx_data | output | 8 | Outgoing packet byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_last | output | 1 | Outgoing byte is the packet's last |
| tx_ready | input | 1 | Sink accepts the outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with MAX_LEN = 16 and IRQ_LINE = 5. The small store lets a 20-byte arrival reach the discard path of R5 and a length write of 100 reach the clipping of R6 within a few dozen cycles. Every byte position of a full store is then read back and sent out in a short run. The odd IRQ_LINE and the default identification string make the read-only words distinguishable from reset zeros.

// File: rtl/pktport_pkg.sv
package pktport_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_HOLD = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LOAD = 2'd1,
        TX_SEND = 2'd2
    } tx_state_t;

    localparam logic [3:0] WD_ID_LO  = 4'd0;
    localparam logic [3:0] WD_ID_HI  = 4'd1;
    localparam logic [3:0] WD_BUSY   = 4'd2;
    localparam logic [3:0] WD_RXCNT  = 4'd3;
    localparam logic [3:0] WD_TXCNT  = 4'd4;
    localparam logic [3:0] WD_INTCTL = 4'd5;
    localparam logic [3:0] WD_INFO   = 4'd6;
    localparam logic [3:0] WD_RXPORT = 4'd7;
    localparam logic [3:0] WD_TXPORT = 4'd8;

    localparam int IC_TXDONE = 0;
    localparam int IC_RXPEND = 1;
    localparam int IC_TEST   = 31;

endpackage

// File: rtl/pktport_rx.sv
module pktport_rx
    import pktport_pkg::*;
#(
    parameter int MAX_LEN = 256,
    parameter int CNT_W   = $clog2(MAX_LEN + 1),
    parameter int PTR_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             port_rd,
    input  logic             ack,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] count,
    output logic             pending,
    output logic             filling
);

    rx_state_t        st, st_nx;
    logic [7:0]       mem [MAX_LEN];
    logic [CNT_W-1:0] wr_cnt;
    logic [CNT_W-1:0] fill_nx;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] widx;
    logic             beat;
    logic             room;

    assign beat    = in_valid && in_ready;
    assign room    = (st == RX_IDLE) || (wr_cnt < CNT_W'(MAX_LEN));
    assign fill_nx = (wr_cnt < CNT_W'(MAX_LEN)) ? wr_cnt + 1'b1 : wr_cnt;
    assign widx    = (st == RX_IDLE) ? '0 : wr_cnt[PTR_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE: if (beat) st_nx = in_last ? RX_HOLD : RX_FILL;
            RX_FILL: if (beat && in_last) st_nx = RX_HOLD;
            RX_HOLD: if (ack) st_nx = RX_IDLE;
            default: st_nx = RX_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        in_ready = (st != RX_HOLD);
        pending  = (st == RX_HOLD);
        filling  = (st == RX_FILL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            count  <= '0;
            rd_ptr <= '0;
        end else if (beat) begin
            if (st == RX_IDLE) begin
                wr_cnt <= CNT_W'(1);
                rd_ptr <= '0;
                count  <= in_last ? CNT_W'(1) : '0;
            end else begin
                wr_cnt <= fill_nx;
                if (in_last) count <= fill_nx;
            end
        end else if (port_rd && count != '0) begin
            count  <= count - 1'b1;
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (beat && room) mem[widx] <= in_data;
    end

    assign rd_byte = (count != '0) ? mem[rd_ptr] : 8'h00;

    AST_RX_LEN_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        beat && in_last |=> pending && count != '0); // R2
    AST_RX_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd && count != '0 && !beat |=> count == $past(count) - 1'b1); // R3
    AST_RX_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !ack |=> pending && !in_ready); // R4
    AST_RX_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_LEN)); // R5

endmodule

// File: rtl/pktport_tx.sv
module pktport_tx
    import pktport_pkg::*;
#(
    parameter int MAX_LEN = 256,
    parameter int CNT_W   = $clog2(MAX_LEN + 1),
    parameter int PTR_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [CNT_W-1:0] len_val,
    input  logic             byte_wr,
    input  logic [7:0]       byte_val,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready,
    output logic [CNT_W-1:0] count,
    output logic             sending,
    output logic             done
);

    tx_state_t        st, st_nx;
    logic [7:0]       mem [MAX_LEN];
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] wr_cnt;
    logic [PTR_W-1:0] rd_ptr;
    logic             arm;
    logic             store;

    assign arm   = len_wr && (st == TX_IDLE) && (len_val != '0);
    assign store = byte_wr && (st == TX_LOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: if (arm) st_nx = TX_LOAD;
            TX_LOAD: if (store && (wr_cnt + 1'b1 == len)) st_nx = TX_SEND;
            TX_SEND: if (out_ready && out_last) st_nx = TX_IDLE;
            default: st_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (st == TX_SEND);
        sending   = (st == TX_SEND);
        count     = (st == TX_LOAD) ? len : '0;
        out_last  = (st == TX_SEND) && (CNT_W'(rd_ptr) == len - 1'b1);
        done      = (st == TX_SEND) && out_ready && out_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len    <= '0;
            wr_cnt <= '0;
            rd_ptr <= '0;
        end else begin
            if (arm) begin
                len    <= len_val;
                wr_cnt <= '0;
            end
            if (store) begin
                wr_cnt <= wr_cnt + 1'b1;
                rd_ptr <= '0;
            end
            if (out_valid && out_ready && !out_last) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (store) mem[wr_cnt[PTR_W-1:0]] <= byte_val;
    end

    assign out_data = mem[rd_ptr];

    AST_TX_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> count == '0); // R6
    AST_TX_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R7

endmodule

// File: rtl/pktport_top.sv
module pktport_top
    import pktport_pkg::*;
#(
    parameter int          MAX_LEN  = 256,
    parameter int          IRQ_LINE = 2,
    parameter logic [63:0] DEV_ID   = "PKTPORT1"
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_word,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);

    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam int PTR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic             rd_en, wr_en;
    logic             rx_port_rd, rx_ack;
    logic [7:0]       rx_byte;
    logic [CNT_W-1:0] rx_count, tx_count, len_clip;
    logic             rx_pend, rx_filling;
    logic             tx_len_wr, tx_byte_wr, tx_sending, tx_done;
    logic             tx_pend, test_flag, test_irq;
    logic             ctl_wr, ctl_rd;

    assign rd_en      = bus_sel && !bus_wr;
    assign wr_en      = bus_sel && bus_wr;
    assign ctl_wr     = wr_en && (bus_word == WD_INTCTL);
    assign ctl_rd     = rd_en && (bus_word == WD_INTCTL);
    assign rx_port_rd = rd_en && (bus_word == WD_RXPORT);
    assign rx_ack     = ctl_wr && bus_wdata[IC_RXPEND];
    assign tx_len_wr  = wr_en && (bus_word == WD_TXCNT);
    assign tx_byte_wr = wr_en && (bus_word == WD_TXPORT);
    assign len_clip   = (bus_wdata > 32'(MAX_LEN)) ? CNT_W'(MAX_LEN) : bus_wdata[CNT_W-1:0];

    pktport_rx #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .PTR_W(PTR_W)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_data (rx_data),
        .in_valid(rx_valid),
        .in_last (rx_last),
        .in_ready(rx_ready),
        .port_rd (rx_port_rd),
        .ack     (rx_ack),
        .rd_byte (rx_byte),
        .count   (rx_count),
        .pending (rx_pend),
        .filling (rx_filling)
    );

    pktport_tx #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .PTR_W(PTR_W)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_wr   (tx_len_wr),
        .len_val  (len_clip),
        .byte_wr  (tx_byte_wr),
        .byte_val (bus_wdata[7:0]),
        .out_data (tx_data),
        .out_valid(tx_valid),
        .out_last (tx_last),
        .out_ready(tx_ready),
        .count    (tx_count),
        .sending  (tx_sending),
        .done     (tx_done)
    );

    // interrupt flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_pend   <= 1'b0;
            test_flag <= 1'b0;
            test_irq  <= 1'b0;
        end else begin
            if (tx_done)                              tx_pend <= 1'b1;
            else if (ctl_wr && bus_wdata[IC_TXDONE])  tx_pend <= 1'b0;

            if (ctl_wr && bus_wdata[IC_TEST]) begin
                test_flag <= 1'b1;
                test_irq  <= 1'b1;
            end else if (ctl_wr && bus_wdata == 32'd0) begin
                test_irq  <= 1'b0;
            end else if (ctl_rd) begin
                test_flag <= 1'b0;
            end
        end
    end

    assign irq = tx_pend || rx_pend || test_irq;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_word)
            WD_ID_LO:  bus_rdata = DEV_ID[31:0];
            WD_ID_HI:  bus_rdata = DEV_ID[63:32];
            WD_BUSY:   bus_rdata = {31'd0, rx_filling || tx_sending};
            WD_RXCNT:  bus_rdata = 32'(rx_count);
            WD_TXCNT:  bus_rdata = 32'(tx_count);
            WD_INTCTL: bus_rdata = {test_flag, 29'd0, rx_pend, tx_pend};
            WD_INFO:   bus_rdata = 32'(IRQ_LINE);
            WD_RXPORT: bus_rdata = {24'd0, rx_byte};
            default:   bus_rdata = '0;
        endcase
    end

    AST_TEST_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd |=> !test_flag); // R9
    AST_TEST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        test_irq && !(ctl_wr && bus_wdata == 32'd0) |=> test_irq); // R9
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> tx_pend && irq); // R8
    AST_IRQ_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pend || test_irq) |-> irq); // R10

endmodule

// File: tb/pktport_tb.sv
module pktport_top_tb_top;

    localparam int          MAXL  = 16;
    localparam int          LINE  = 5;
    localparam logic [63:0] IDV   = "PKTPORT1";

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic        irq;

    always #5 clk = ~clk;

    pktport_top #(.MAX_LEN(MAXL), .IRQ_LINE(LINE), .DEV_ID(IDV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .irq(irq)
    );

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;
    bit throttle = 0;
    int cyc = 0;

    // reference model
    int         m_rxs = 0, m_txs = 0, m_txlen = 0, m_txidx = 0;
    logic [7:0] m_rxq[$], m_fill[$], m_txq[$];
    logic [8:0] src_q[$];
    bit         m_txpend = 0, m_tflag = 0, m_tirq = 0;
    bit         s_rd, s_wr, s_rxacc, s_txacc;
    int         s_w, s_len;

    function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endfunction

    function automatic logic [31:0] m_read(input int w);
        case (w)
            0: return IDV[31:0];
            1: return IDV[63:32];
            2: return {31'd0, (m_rxs == 1) || (m_txs == 2)};
            3: return 32'(m_rxq.size());
            4: return (m_txs == 1) ? 32'(m_txlen) : 32'd0;
            5: return {m_tflag, 29'd0, m_rxs == 2, m_txpend};
            6: return 32'(LINE);
            7: return (m_rxq.size() > 0) ? {24'd0, m_rxq[0]} : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_rxs = 0; m_txs = 0; m_txlen = 0; m_txidx = 0;
            m_rxq.delete(); m_fill.delete(); m_txq.delete();
            m_txpend = 0; m_tflag = 0; m_tirq = 0;
        end else begin
            s_rd = bus_sel && !bus_wr;
            s_wr = bus_sel && bus_wr;
            s_w = int'(bus_word);
            s_rxacc = rx_valid && (m_rxs != 2);
            s_txacc = (m_txs == 2) && tx_ready;
            if (s_rd && s_w == 7 && m_rxq.size() > 0) void'(m_rxq.pop_front());
            if (s_wr && s_w == 5) begin
                if (bus_wdata[31]) begin m_tflag = 1; m_tirq = 1; end
                else if (bus_wdata == 0) m_tirq = 0;
                if (bus_wdata[0]) m_txpend = 0;
                if (bus_wdata[1] && m_rxs == 2) m_rxs = 0;
            end else if (s_rd && s_w == 5) m_tflag = 0;
            if (s_wr && s_w == 4) begin
                s_len = (bus_wdata > 32'(MAXL)) ? MAXL : int'(bus_wdata);
                if (m_txs == 0 && s_len != 0) begin
                    m_txlen = s_len; m_txq.delete(); m_txs = 1;
                end
            end
            if (s_wr && s_w == 8 && m_txs == 1) begin
                m_txq.push_back(bus_wdata[7:0]);
                if (m_txq.size() == m_txlen) begin m_txs = 2; m_txidx = 0; end
            end
            if (s_txacc) begin
                if (m_txidx == m_txlen - 1) begin m_txs = 0; m_txpend = 1; end
                else m_txidx++;
            end
            if (s_rxacc) begin
                void'(src_q.pop_front());
                if (m_rxs == 0) begin m_fill.delete(); m_rxq.delete(); end
                if (m_fill.size() < MAXL) m_fill.push_back(rx_data);
                if (rx_last) begin m_rxq = m_fill; m_rxs = 2; end
                else m_rxs = 1;
            end
        end
    end

    // per-cycle comparison and stream drive
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R10 irq", {31'd0, irq}, {31'd0, m_txpend || m_rxs == 2 || m_tirq});
            chk("R4 rx_ready", {31'd0, rx_ready}, {31'd0, m_rxs != 2});
            chk("R7 tx_valid", {31'd0, tx_valid}, {31'd0, m_txs == 2});
            if (m_txs == 2) begin
                chk("R7 tx_data", {24'd0, tx_data}, {24'd0, m_txq[m_txidx]});
                chk("R7 tx_last", {31'd0, tx_last}, {31'd0, m_txidx == m_txlen - 1});
            end
        end
        rx_valid = src_q.size() > 0;
        rx_data  = (src_q.size() > 0) ? src_q[0][7:0] : 8'h00;
        rx_last  = (src_q.size() > 0) ? src_q[0][8] : 1'b0;
        tx_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
    end

    task automatic bus_op(input bit wr, input int w, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_word = 4'(w); bus_wdata = d;
        #1;
        if (!wr) chk(tag, bus_rdata, m_read(w));
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input int w, input logic [31:0] d);
        bus_op(1'b1, w, d, "");
    endtask

    task automatic rd(input int w, input string tag);
        bus_op(1'b0, w, 32'd0, tag);
    endtask

    task automatic push_pkt(input int n, input int base);
        for (int i = 0; i < n; i++) src_q.push_back({i == n - 1, 8'(base + i)});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done_flag = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog: actual running expected finished");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R12 reset state, R1 fixed words
        for (int w = 0; w < 10; w++) rd(w, "R12 R1 reset read");
        rd(11, "R1 unmapped");
        wr(0, 32'hDEAD_BEEF); wr(6, 32'h1F);
        rd(0, "R1 id lo after write"); rd(6, "R1 info after write");
        // R9 self-test
        wr(5, 32'h8000_0000); idle(2);
        rd(5, "R9 test bit set"); rd(5, "R9 test bit cleared by read");
        wr(5, 32'h0000_0002); idle(2);
        rd(5, "R9 line held");
        wr(5, 32'h0); idle(2);
        // R2 R3 R11 receive
        push_pkt(5, 8'h10);
        rd(2, "R11 busy during fill"); rd(3, "R2 count during fill");
        idle(6);
        rd(2, "R11 busy idle"); rd(3, "R2 count loaded"); rd(5, "R2 pending bit");
        for (int i = 0; i < 6; i++) rd(7, "R3 port read");
        rd(3, "R3 count empty");
        // R4 blocked while pending
        push_pkt(3, 8'h40); idle(6);
        rd(3, "R4 blocked count");
        wr(5, 32'h1); idle(2); rd(5, "R4 tx-done write leaves rx bit");
        wr(5, 32'h2); idle(6);
        rd(3, "R4 after ack");
        for (int i = 0; i < 3; i++) rd(7, "R4 R3 new packet read");
        wr(5, 32'h2); wr(5, 32'h2); idle(2);
        // R5 oversized
        push_pkt(20, 8'h80);
        rd(2, "R11 busy long fill");
        idle(22);
        rd(3, "R5 truncated count");
        for (int i = 0; i < 17; i++) rd(7, "R5 stored bytes");
        wr(5, 32'h2);
        // R6 R7 R8 transmit
        throttle = 1;
        wr(8, 32'h55); rd(4, "R7 stray byte ignored");
        wr(4, 32'd4); rd(4, "R6 armed length");
        wr(4, 32'd9); rd(4, "R6 rearm ignored");
        for (int i = 0; i < 4; i++) begin
            wr(8, 32'hFFFF_FF00 | 32'(8'hA0 + i));
            rd(4, "R6 count while loading");
        end
        wr(8, 32'hEE); rd(2, "R11 busy sending");
        idle(15);
        rd(5, "R8 done bit"); wr(5, 32'h1); idle(1); rd(5, "R8 cleared");
        wr(4, 32'd0); rd(4, "R6 zero ignored");
        wr(4, 32'd100); rd(4, "R6 clipped");
        for (int i = 0; i < 16; i++) wr(8, 32'(8'hC0 + i));
        rd(4, "R6 cleared on take");
        idle(40); wr(5, 32'h1);
        // concurrent
        throttle = 0;
        push_pkt(6, 8'h20);
        wr(4, 32'd3);
        for (int i = 0; i < 3; i++) wr(8, 32'(8'h30 + i));
        idle(10);
        rd(5, "R10 both pending");
        for (int i = 0; i < 6; i++) rd(7, "R3 concurrent read");
        wr(5, 32'h3); idle(3);
        rd(5, "R8 R4 both cleared");
        idle(3);
        summary();
    end

endmodule